// File: doc/BRIEF.md
# Programmable Reference/VCO Divider with Phase Comparator

This block is the digital half of a frequency synthesizer that steers an external oscillator toward a wanted pixel-clock rate. Two 6-bit counters, each programmed with its modulus minus one, divide a reference event stream and a VCO event stream. A phase comparator then turns the two divided pulse trains into a single steering level, `pcomp`, for the external loop filter. The level rises on each divided-reference pulse and falls on each divided-VCO pulse, so its duty grows with the reference's phase lead.

Everything runs on one fast system clock. The reference and VCO clocks are presented as one-cycle event strobes, `refTick` and `vcoTick`, which have already been brought into this domain. One 32-bit control word is written through a simple write port and is accepted only when its top nibble selects this register. Four test bits in that word can force the comparator level high or low, or hold either counter cleared. The illegal case with both force bits set is resolved safely: the output is held low and an error flag is raised.

Top module: `pllFreqSynth`

## Requirements
- R1: After reset `pcomp`, `refDiv`, `vcoDiv` and `cfgError` are 0, and both moduli fields start at 63 (divide by 64), with both counters at zero.
- R2: A write is accepted only when `wrEn` is 1 and `wrData[31:28]` equals 4'b1101. Any other write leaves every output and every count unchanged.
- R3: The reference modulus sits in `wrData[5:0]`. A field value k makes `refDiv` pulse high for one cycle on every (k+1)-th `refTick`. The pulse appears in the cycle after the edge that samples that tick.
- R4: The VCO modulus sits in `wrData[13:8]`. A field value k makes `vcoDiv` pulse for one cycle on every (k+1)-th `vcoTick`, with the same timing as R3.
- R5: A newly written modulus does not disturb the count in progress. The divider adopts it at its next terminal count, or at once if its counter is being held cleared.
- R6: While bit 7 of the stored word is 1, the reference counter is held at zero and `refDiv` stays 0. After release, the first pulse comes on the (k+1)-th tick.
- R7: While bit 15 of the stored word is 1, the VCO counter is held at zero and `vcoDiv` stays 0. After release, the first pulse comes on the (k+1)-th tick.
- R8: While bit 6 of the stored word is 1 and bit 14 is 0, `pcomp` is 1 from the second cycle after the write, whatever the divided pulses do.
- R9: While bit 14 of the stored word is 1, `pcomp` is 0 from the second cycle after the write.
- R10: `cfgError` is 1 exactly while the stored word has both bit 6 and bit 14 set, from the cycle after the write. In that state `pcomp` is held 0.
- R11: With no force bit set, `pcomp` becomes 1 in the cycle after a `refDiv` pulse and 0 in the cycle after a `vcoDiv` pulse. When both pulses occur in the same cycle, `pcomp` keeps its value.
- R12: Bits 27:16 of an accepted word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word; top nibble selects the register |
| refTick | input | 1 | One-cycle event per reference clock period |
| vcoTick | input | 1 | One-cycle event per VCO clock period |
| refDiv | output | 1 | One-cycle pulse at each reference terminal count |
| vcoDiv | output | 1 | One-cycle pulse at each VCO terminal count |
| pcomp | output | 1 | Phase comparator steering level |
| cfgError | output | 1 | Both force bits set in the stored word |

## Verification
The two divided pulses can land in the same cycle. That is the moment the comparator must hold its level instead of choosing one edge. The bench provokes it by programming both moduli to zero with both ticks present every cycle, and again with random tick patterns and unequal moduli. A second coincidence is a modulus write that arrives part-way through a count. The bench checks that the old terminal count still completes and the new ratio starts only afterwards. A behavioural model predicts `pcomp`, both divided pulses and the error flag for every cycle, and the outputs are compared against it.

// File: rtl/fsynPkg.sv
`timescale 1ns/1ps
package fsynPkg;
  localparam int DATA_W    = 32;
  localparam int MOD_W     = 6;
  localparam int SEL_W     = 4;
  localparam logic [SEL_W-1:0] SEL_CODE = 4'b1101;
  localparam int NUM_DIV   = 2;
  localparam int REF_LSB   = 0;
  localparam int REF_HIGH  = 6;
  localparam int REF_CLR   = 7;
  localparam int VCO_LSB   = 8;
  localparam int VCO_LOW   = 14;
  localparam int VCO_CLR   = 15;

  typedef struct packed {
    logic             refClear;
    logic             vcoClear;
    logic             forceHigh;
    logic             forceLow;
    logic [MOD_W-1:0] refMod;
    logic [MOD_W-1:0] vcoMod;
  } fsynStrobes_t;
endpackage

// File: rtl/fsynModDiv.sv
`timescale 1ns/1ps
module fsynModDiv #(
  parameter int MOD_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             clear,
  input  logic [MOD_W-1:0] progMod,
  output logic             tcPulse
);
  logic [MOD_W-1:0] cnt;
  logic [MOD_W-1:0] actMod;
  logic             atEnd;

  assign atEnd = (cnt == actMod);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      actMod  <= '1;
      tcPulse <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      actMod  <= progMod;
      tcPulse <= 1'b0;
    end else begin
      tcPulse <= tick && atEnd;
      if (tick) begin
        if (atEnd) begin
          cnt    <= '0;
          actMod <= progMod;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsynCtrl.sv
`timescale 1ns/1ps
module fsynCtrl
  import fsynPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output fsynStrobes_t      strb,
  output logic              cfgError
);
  logic selHit;
  logic unusedHi;

  assign selHit   = wrEn && (wrData[DATA_W-1 -: SEL_W] == SEL_CODE);
  assign unusedHi = ^wrData[DATA_W-SEL_W-1:VCO_CLR+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb.refClear  <= 1'b0;
      strb.vcoClear  <= 1'b0;
      strb.forceHigh <= 1'b0;
      strb.forceLow  <= 1'b0;
      strb.refMod    <= '1;
      strb.vcoMod    <= '1;
      cfgError       <= 1'b0;
    end else if (selHit) begin
      strb.refClear  <= wrData[REF_CLR];
      strb.vcoClear  <= wrData[VCO_CLR];
      strb.forceHigh <= wrData[REF_HIGH];
      strb.forceLow  <= wrData[VCO_LOW];
      strb.refMod    <= wrData[REF_LSB +: MOD_W];
      strb.vcoMod    <= wrData[VCO_LSB +: MOD_W];
      cfgError       <= wrData[REF_HIGH] & wrData[VCO_LOW];
    end
  end
endmodule

// File: rtl/fsynDatapath.sv
`timescale 1ns/1ps
module fsynDatapath
  import fsynPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  fsynStrobes_t strb,
  input  logic         refTick,
  input  logic         vcoTick,
  output logic         refDiv,
  output logic         vcoDiv,
  output logic         pcomp
);
  logic [NUM_DIV-1:0] tickVec;
  logic [NUM_DIV-1:0] clrVec;
  logic [NUM_DIV-1:0] tcVec;
  logic [MOD_W-1:0]   progVec [NUM_DIV];

  assign tickVec    = {vcoTick, refTick};
  assign clrVec     = {strb.vcoClear, strb.refClear};
  assign progVec[0] = strb.refMod;
  assign progVec[1] = strb.vcoMod;

  for (genvar g = 0; g < NUM_DIV; g++) begin : gDiv
    fsynModDiv #(.MOD_W(MOD_W)) u_div (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (tickVec[g]),
      .clear   (clrVec[g]),
      .progMod (progVec[g]),
      .tcPulse (tcVec[g])
    );
  end

  assign refDiv = tcVec[0];
  assign vcoDiv = tcVec[1];

  // Low force wins, which also covers the illegal both-forced case.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcomp <= 1'b0;
    end else if (strb.forceLow) begin
      pcomp <= 1'b0;
    end else if (strb.forceHigh) begin
      pcomp <= 1'b1;
    end else if (refDiv && !vcoDiv) begin
      pcomp <= 1'b1;
    end else if (vcoDiv && !refDiv) begin
      pcomp <= 1'b0;
    end
  end
endmodule

// File: rtl/pllFreqSynth.sv
`timescale 1ns/1ps
module pllFreqSynth
  import fsynPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              refTick,
  input  logic              vcoTick,
  output logic              refDiv,
  output logic              vcoDiv,
  output logic              pcomp,
  output logic              cfgError
);
  fsynStrobes_t strb;

  fsynCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .strb     (strb),
    .cfgError (cfgError)
  );

  fsynDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .refTick (refTick),
    .vcoTick (vcoTick),
    .refDiv  (refDiv),
    .vcoDiv  (vcoDiv),
    .pcomp   (pcomp)
  );
endmodule

// File: rtl/fsynChecker.sv
`timescale 1ns/1ps
module fsynChecker
  import fsynPkg::*;
(
  input logic         clk,
  input logic         rstN,
  input fsynStrobes_t strb,
  input logic         refDiv,
  input logic         vcoDiv,
  input logic         pcomp,
  input logic         cfgError
);
  assert_ref_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.refClear |=> !refDiv);

  assert_vco_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.vcoClear |=> !vcoDiv);

  assert_force_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.forceHigh && !strb.forceLow) |=> pcomp);

  assert_force_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceLow |=> !pcomp);

  assert_conflict_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> !pcomp);

  assert_ref_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    (refDiv && !vcoDiv && !strb.forceHigh && !strb.forceLow) |=> pcomp);

  assert_vco_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    (vcoDiv && !refDiv && !strb.forceHigh && !strb.forceLow) |=> !pcomp);

  assert_coincide_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (vcoDiv && refDiv && !strb.forceHigh && !strb.forceLow) |=> $stable(pcomp));
endmodule

bind pllFreqSynth fsynChecker u_fsynChecker (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .refDiv   (refDiv),
  .vcoDiv   (vcoDiv),
  .pcomp    (pcomp),
  .cfgError (cfgError)
);

// File: tb/pllFreqSynth_bench.sv
`timescale 1ns/1ps
module pllFreqSynth_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        refTick = 1'b0;
  logic        vcoTick = 1'b0;
  logic        refDiv, vcoDiv, pcomp, cfgError;

  int    vectors = 0;
  int    miscompares = 0;
  bit    started = 0;
  bit    finished = 0;
  string curReq = "R1";
  int    tickMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural expectation
  int eRefCnt = 0, eRefAct = 63, eRefProg = 63;
  int eVcoCnt = 0, eVcoAct = 63, eVcoProg = 63;
  bit eRefDiv = 0, eVcoDiv = 0, ePcomp = 0, eErr = 0;
  bit eRC = 0, eVC = 0, eFH = 0, eFL = 0;

  always #2.5 clk = ~clk;

  pllFreqSynth u_pllFreqSynth (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .refTick(refTick), .vcoTick(vcoTick),
    .refDiv(refDiv), .vcoDiv(vcoDiv), .pcomp(pcomp), .cfgError(cfgError)
  );

  always @(posedge clk) begin
    int  nRefCnt, nRefAct, nVcoCnt, nVcoAct;
    bit  nRefDiv, nVcoDiv, nPcomp;
    started = 1;
    if (!rstN) begin
      eRefCnt = 0; eRefAct = 63; eRefProg = 63;
      eVcoCnt = 0; eVcoAct = 63; eVcoProg = 63;
      eRefDiv = 0; eVcoDiv = 0; ePcomp = 0; eErr = 0;
      eRC = 0; eVC = 0; eFH = 0; eFL = 0;
    end else begin
      nPcomp = ePcomp;
      if (eFL) nPcomp = 0;
      else if (eFH) nPcomp = 1;
      else if (eRefDiv && !eVcoDiv) nPcomp = 1;
      else if (eVcoDiv && !eRefDiv) nPcomp = 0;
      nRefCnt = eRefCnt; nRefAct = eRefAct; nRefDiv = 0;
      if (eRC) begin nRefCnt = 0; nRefAct = eRefProg; end
      else if (refTick) begin
        if (eRefCnt == eRefAct) begin nRefCnt = 0; nRefAct = eRefProg; nRefDiv = 1; end
        else nRefCnt = eRefCnt + 1;
      end
      nVcoCnt = eVcoCnt; nVcoAct = eVcoAct; nVcoDiv = 0;
      if (eVC) begin nVcoCnt = 0; nVcoAct = eVcoProg; end
      else if (vcoTick) begin
        if (eVcoCnt == eVcoAct) begin nVcoCnt = 0; nVcoAct = eVcoProg; nVcoDiv = 1; end
        else nVcoCnt = eVcoCnt + 1;
      end
      if (wrEn && wrData[31:28] == 4'b1101) begin
        eRefProg = int'(wrData[5:0]);
        eVcoProg = int'(wrData[13:8]);
        eFH = wrData[6]; eRC = wrData[7];
        eFL = wrData[14]; eVC = wrData[15];
        eErr = wrData[6] && wrData[14];
      end
      eRefCnt = nRefCnt; eRefAct = nRefAct; eRefDiv = nRefDiv;
      eVcoCnt = nVcoCnt; eVcoAct = nVcoAct; eVcoDiv = nVcoDiv;
      ePcomp = nPcomp;
    end
  end

  task automatic check1(string what, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check1("refDiv", refDiv, eRefDiv);
      check1("vcoDiv", vcoDiv, eVcoDiv);
      check1("pcomp", pcomp, ePcomp);
      check1("cfgError", cfgError, eErr);
    end
  end

  function automatic logic [31:0] mkWord(logic [3:0] sel, logic [11:0] hi,
      bit vClr, bit fLow, int v, bit rClr, bit fHigh, int r);
    return {sel, hi, vClr, fLow, 6'(v), rClr, fHigh, 6'(r)};
  endfunction

  task automatic driveTicks();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tickMode)
      0: begin refTick = 0; vcoTick = 0; end
      1: begin refTick = 1; vcoTick = 1; end
      2: begin refTick = lfsr[0]; vcoTick = lfsr[5]; end
      default: begin refTick = 1; vcoTick = lfsr[3]; end
    endcase
  endtask

  task automatic run(int n);
    repeat (n) begin @(negedge clk); driveTicks(); end
  endtask

  task automatic doWrite(logic [31:0] w);
    @(negedge clk); wrEn = 1; wrData = w; driveTicks();
    @(negedge clk); wrEn = 0; driveTicks();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    curReq = "R1"; tickMode = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    run(10);
    curReq = "R3"; tickMode = 1; run(140);
    curReq = "R6"; doWrite(mkWord(4'hD, 0, 1, 0, 6, 1, 0, 4)); run(6);
    curReq = "R4"; doWrite(mkWord(4'hD, 0, 0, 0, 6, 0, 0, 4)); run(60);
    curReq = "R11"; tickMode = 2; run(200);
    curReq = "R5"; run(3); doWrite(mkWord(4'hD, 0, 0, 0, 2, 0, 0, 9)); run(80);
    curReq = "R2"; doWrite(mkWord(4'hC, 0, 1, 0, 1, 1, 1, 1));
    doWrite(mkWord(4'h5, 0, 0, 1, 0, 0, 0, 0)); run(40);
    curReq = "R12"; doWrite(mkWord(4'hD, 12'hFFF, 0, 0, 3, 0, 0, 2)); run(60);
    curReq = "R8"; doWrite(mkWord(4'hD, 0, 0, 0, 3, 0, 1, 2)); run(30);
    curReq = "R9"; doWrite(mkWord(4'hD, 0, 0, 1, 3, 0, 0, 2)); run(30);
    curReq = "R10"; doWrite(mkWord(4'hD, 0, 0, 1, 3, 0, 1, 2)); run(20);
    doWrite(mkWord(4'hD, 0, 0, 0, 3, 0, 0, 2)); run(20);
    curReq = "R7"; tickMode = 1; doWrite(mkWord(4'hD, 0, 1, 0, 3, 0, 0, 2)); run(30);
    curReq = "R6"; doWrite(mkWord(4'hD, 0, 0, 0, 3, 1, 0, 2)); run(30);
    curReq = "R11"; doWrite(mkWord(4'hD, 0, 1, 0, 0, 1, 0, 0));
    doWrite(mkWord(4'hD, 0, 0, 0, 0, 0, 0, 0)); run(30);
    tickMode = 3; doWrite(mkWord(4'hD, 0, 0, 0, 1, 0, 0, 2)); run(60);
    tickMode = 2; run(100);
    finishRun();
  end
endmodule